// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Per-Pin Interrupts

The block is one GPIO port of up to 32 pins on an APB-style register bus. Software sets an output value register and a direction register, which drive the pin outputs and their output enables straight away. Software reads the pin levels through a two-flop synchronizer.

Every pin has its own interrupt qualifier. An enable bit and a mask bit gate the pin. A type bit chooses between following the level and latching an edge. A polarity bit chooses which level or which edge is active. The qualified bits appear in a status register. Edge-latched bits are released by writing ones at their positions to a write-only clear register. A single interrupt line is raised while any status bit is set. A spare register gives software storage for a filter setting and has no effect on the pins.

A write takes effect when `psel`, `penable` and `pwrite` are all high at a rising clock edge. Read data is combinational on the address while `psel` is high. The register map uses word offsets: 0x00 output value, 0x04 direction, 0x30 enable, 0x34 type, 0x38 polarity, 0x3C status, 0x40 clear, 0x44 mask, 0x48 filter storage, 0x50 pin levels.

Top module: `gpio_irq_port`

## Requirements
- R1: While `rst_n` is low, every register is 0. `pin_out`, `pin_oe` and `irq` are 0, and every register reads 0.
- R2: The value register (0x00) drives `pin_out`, and the direction register (0x04) drives `pin_oe` (1 = output). Both read back what was written. A write commits only when `psel`, `penable` and `pwrite` are all high at the clock edge.
- R3: The enable (0x30), type (0x34), polarity (0x38), mask (0x44) and filter storage (0x48) registers read back the value written. Pin n is bit n in each of them.
- R4: A read of 0x50 returns `pin_in` as it was two rising edges earlier.
- R5: With type bit 0 (level), a status bit is 1 exactly while the synchronized pin equals its polarity bit and the pin is enabled and unmasked. A status bit in this mode never latches.
- R6: With type bit 1 (edge), an active edge latches the pin's status. With polarity 1 the active edge is rising, with polarity 0 it is falling. The latched bit stays set after the pin returns. An edge that arrives while the pin is disabled or in level mode is not recorded.
- R7: Writing to the clear register (0x40) clears each edge-latched bit whose position is 1. The write has no effect on level-mode bits, and the register reads 0. If a new active edge arrives in the same cycle as the clear, the bit stays set.
- R8: The status register (0x3C) shows only bits that are enabled and unmasked. A masked edge-latched bit is kept and reappears when it is unmasked.
- R9: `irq` is 1 exactly when the status register is nonzero.
- R10: Reads of offsets outside the map, unaligned offsets and offsets with high address bits set return 0. Writes to those offsets and to 0x3C or 0x50 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register access select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output values |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench places a clear write in the exact cycle in which a fresh edge reaches the latch. A design that gives the clear priority would lose that interrupt. The bench checks falling-edge and low-level pins, so a design that ignores polarity would miss their events. It unmasks a masked edge bit to confirm that the bit was kept, and it writes to the clear register while level-mode pins are active to confirm that those bits do not drop. A long random phase mixes setup-only cycles, unmapped and unaligned addresses, and pin toggles. That phase exposes any write that commits too early, any aliasing of addresses, and any error in the latency of the synchronizer.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int REG_W = 32;

   // word index = byte offset / 4
   localparam logic [4:0] IDX_OVAL  = 5'd0;   // 0x00
   localparam logic [4:0] IDX_DIR   = 5'd1;   // 0x04
   localparam logic [4:0] IDX_IEN   = 5'd12;  // 0x30
   localparam logic [4:0] IDX_ITYPE = 5'd13;  // 0x34
   localparam logic [4:0] IDX_IPOL  = 5'd14;  // 0x38
   localparam logic [4:0] IDX_ISTAT = 5'd15;  // 0x3C
   localparam logic [4:0] IDX_ICLR  = 5'd16;  // 0x40
   localparam logic [4:0] IDX_IMASK = 5'd17;  // 0x44
   localparam logic [4:0] IDX_FILT  = 5'd18;  // 0x48
   localparam logic [4:0] IDX_LVL   = 5'd20;  // 0x50

   typedef struct packed {
      logic wr;
      logic hit;
      logic [4:0] idx;
   } bus_req_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int NPINS     = 32,
   parameter bit KEEP_FILT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_req_t         req,
   input  logic [REG_W-1:0] wdata,
   input  logic [NPINS-1:0] status_i,
   input  logic [NPINS-1:0] levels_i,
   output logic [NPINS-1:0] oval_o,
   output logic [NPINS-1:0] dir_o,
   output logic [NPINS-1:0] ien_o,
   output logic [NPINS-1:0] itype_o,
   output logic [NPINS-1:0] ipol_o,
   output logic [NPINS-1:0] imask_o,
   output logic [NPINS-1:0] clr_o,
   output logic [REG_W-1:0] rdata
);
   logic [NPINS-1:0] wv;
   logic             wr_hit;
   logic [NPINS-1:0] filt_q;
   logic [NPINS-1:0] rsel;

   assign wv     = wdata[NPINS-1:0];
   assign wr_hit = req.wr && req.hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oval_o  <= '0;
         dir_o   <= '0;
         ien_o   <= '0;
         itype_o <= '0;
         ipol_o  <= '0;
         imask_o <= '0;
      end else if (wr_hit) begin
         case (req.idx)
            IDX_OVAL:  oval_o  <= wv;
            IDX_DIR:   dir_o   <= wv;
            IDX_IEN:   ien_o   <= wv;
            IDX_ITYPE: itype_o <= wv;
            IDX_IPOL:  ipol_o  <= wv;
            IDX_IMASK: imask_o <= wv;
            default: ;
         endcase
      end
   end

   if (KEEP_FILT) begin : g_filt_store
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                             filt_q <= '0;
         else if (wr_hit && req.idx == IDX_FILT) filt_q <= wv;
   end else begin : g_filt_none
      assign filt_q = '0;
   end

   // clear pulse, one cycle, only from an access-phase write
   assign clr_o = (wr_hit && req.idx == IDX_ICLR) ? wv : '0;

   always_comb begin
      rsel = '0;
      if (req.hit) begin
         case (req.idx)
            IDX_OVAL:  rsel = oval_o;
            IDX_DIR:   rsel = dir_o;
            IDX_IEN:   rsel = ien_o;
            IDX_ITYPE: rsel = itype_o;
            IDX_IPOL:  rsel = ipol_o;
            IDX_ISTAT: rsel = status_i;
            IDX_IMASK: rsel = imask_o;
            IDX_FILT:  rsel = filt_q;
            IDX_LVL:   rsel = levels_i;
            default:   rsel = '0;
         endcase
      end
      rdata = '0;
      rdata[NPINS-1:0] = rsel;
   end

   AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o != '0) |-> req.wr) else $error("clear without write"); // R7
   AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req.hit && req.idx == IDX_ICLR) |-> (rdata == '0)) else $error("clear reg readable"); // R7
   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!req.hit) |-> (rdata == '0)) else $error("unmapped read nonzero"); // R10
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl_i,
   input  logic [NPINS-1:0] ien_i,
   input  logic [NPINS-1:0] itype_i,
   input  logic [NPINS-1:0] ipol_i,
   input  logic [NPINS-1:0] imask_i,
   input  logic [NPINS-1:0] clr_i,
   output logic [NPINS-1:0] status_o,
   output logic             irq_o
);
   logic [NPINS-1:0] latch_q;
   logic [NPINS-1:0] evt;

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic prev_q;
      logic hit_q;
      logic active_lvl;
      logic rise, fall;

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl_i[i];

      assign rise       = lvl_i[i] & ~prev_q;
      assign fall       = ~lvl_i[i] & prev_q;
      assign active_lvl = ~(lvl_i[i] ^ ipol_i[i]);
      assign evt[i]     = itype_i[i] & ien_i[i] & (ipol_i[i] ? rise : fall);

      // a fresh edge outranks a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          hit_q <= 1'b0;
         else if (!itype_i[i]) hit_q <= 1'b0;
         else if (evt[i])     hit_q <= 1'b1;
         else if (clr_i[i])   hit_q <= 1'b0;
      end

      assign latch_q[i]  = hit_q;
      assign status_o[i] = ien_i[i] & ~imask_i[i] & (itype_i[i] ? hit_q : active_lvl);
   end

   assign irq_o = |status_o;

   AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & $past(latch_q & itype_i & ~clr_i)) == $past(latch_q & itype_i & ~clr_i)))
      else $error("latched edge lost"); // R6
   AST_EDGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & ~$past((latch_q & ~clr_i) | evt)) == '0))
      else $error("latch set without edge"); // R7
   AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & ~$past(itype_i)) == '0))
      else $error("level pin latched"); // R5
   AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((ien_i & ~imask_i) != '0))
      else $error("irq from gated pin"); // R9
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int NPINS     = 32,
   parameter int ADDR_W    = 8,
   parameter int SYNC_STG  = 2,
   parameter bit KEEP_FILT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   if (NPINS < 1 || NPINS > REG_W) begin : g_bad_npins
      $error("gpio_irq_port: NPINS must be 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_irq_port: ADDR_W must be at least 8");
   end

   bus_req_t         req;
   logic [NPINS-1:0] lvl;
   logic [NPINS-1:0] ien, itype, ipol, imask, clr, status;

   assign req.wr  = psel & penable & pwrite;
   assign req.hit = psel && (paddr[1:0] == 2'b00) && (paddr[ADDR_W-1:7] == '0);
   assign req.idx = paddr[6:2];

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   gpio_regs #(.NPINS(NPINS), .KEEP_FILT(KEEP_FILT)) u_regs (
      .clk(clk), .rst_n(rst_n), .req(req), .wdata(pwdata),
      .status_i(status), .levels_i(lvl),
      .oval_o(pin_out), .dir_o(pin_oe), .ien_o(ien), .itype_o(itype),
      .ipol_o(ipol), .imask_o(imask), .clr_o(clr), .rdata(prdata)
   );

   gpio_irq_core #(.NPINS(NPINS)) u_core (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .ien_i(ien), .itype_i(itype),
      .ipol_i(ipol), .imask_i(imask), .clr_i(clr),
      .status_o(status), .irq_o(irq)
   );

   AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(psel && penable && pwrite) |=> $stable(pin_oe)) else $error("dir changed w/o write"); // R2
   AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(psel && penable && pwrite) |=> $stable(pin_out)) else $error("value changed w/o write"); // R2
endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;

   int nvec = 0, nbad = 0;
   bit done = 1'b0;

   // reference state
   logic [31:0] m_oval, m_dir, m_ien, m_typ, m_pol, m_msk, m_filt;
   logic [31:0] m_s1, m_s2, m_prev, m_edge;

   always #10 clk = ~clk;   // 50 MHz

   gpio_irq_port u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   function automatic logic [31:0] m_status();
      logic [31:0] st = '0;
      for (int i = 0; i < 32; i++) begin
         bit raw;
         if (m_typ[i]) raw = m_edge[i];
         else          raw = (m_s2[i] == m_pol[i]);
         st[i] = raw && m_ien[i] && !m_msk[i];
      end
      return st;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return m_oval;
         8'h04: return m_dir;
         8'h30: return m_ien;
         8'h34: return m_typ;
         8'h38: return m_pol;
         8'h3C: return m_status();
         8'h44: return m_msk;
         8'h48: return m_filt;
         8'h50: return m_s2;
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_reset();
      m_oval = 0; m_dir = 0; m_ien = 0; m_typ = 0; m_pol = 0; m_msk = 0; m_filt = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_edge = 0;
   endtask

   task automatic m_clock();
      logic [31:0] clr = '0;
      logic [31:0] nedge;
      bit acc = psel && penable && pwrite;
      if (acc && paddr == 8'h40) clr = pwdata;
      for (int i = 0; i < 32; i++) begin
         bit active_edge = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
         bit ev = m_typ[i] && m_ien[i] && active_edge;
         nedge[i] = m_typ[i] ? (ev || (m_edge[i] && !clr[i])) : 1'b0;
      end
      m_edge = nedge;
      if (acc) begin
         case (paddr)
            8'h00: m_oval = pwdata;
            8'h04: m_dir  = pwdata;
            8'h30: m_ien  = pwdata;
            8'h34: m_typ  = pwdata;
            8'h38: m_pol  = pwdata;
            8'h44: m_msk  = pwdata;
            8'h48: m_filt = pwdata;
            default: ;
         endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
   endtask

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // drive one cycle, check combinational view, then advance the model
   task automatic step(input string tag, input bit sel, input bit en, input bit wr,
                       input logic [7:0] a, input logic [31:0] d, input logic [31:0] pins);
      psel = sel; penable = en; pwrite = wr; paddr = a; pwdata = d; pin_in = pins;
      #2;
      cmp(tag, "pin_out", pin_out, m_oval);
      cmp(tag, "pin_oe", pin_oe, m_dir);
      cmp(tag, "irq", {31'b0, irq}, {31'b0, (m_status() != 0)});
      if (sel && !wr) cmp(tag, "prdata", prdata, m_read(a));
      @(posedge clk);
      if (rst_n) m_clock(); else m_reset();
      @(negedge clk);
   endtask

   task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
      step(tag, 1, 1, 1, a, d, pin_in);
   endtask
   task automatic rd(input string tag, input logic [7:0] a);
      step(tag, 1, 1, 0, a, 0, pin_in);
   endtask
   task automatic idle(input string tag, input logic [31:0] pins);
      step(tag, 0, 0, 0, 0, 0, pins);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic [31:0] pins;
      logic [7:0] amap [12] = '{8'h00, 8'h04, 8'h30, 8'h34, 8'h38, 8'h3C,
                               8'h40, 8'h44, 8'h48, 8'h50, 8'h5C, 8'h80};
      m_reset();
      @(negedge clk);
      // R1: reset view
      pin_in = 32'hFFFF_FFFF;
      for (int k = 0; k < 10; k++) rd("R1", amap[k]);
      pin_in = '0;
      step("R1", 0, 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      idle("R1", 0); idle("R1", 0); idle("R1", 0);

      // R2: value/direction, setup phase must not commit
      wr("R2", 8'h00, 32'hA5A5_0F0F);
      wr("R2", 8'h04, 32'hFFFF_0000);
      step("R2", 1, 0, 1, 8'h00, 32'h1234_5678, 0);
      rd("R2", 8'h00); rd("R2", 8'h04);

      // R3: configuration readback
      wr("R3", 8'h48, 32'hDEAD_BEEF); rd("R3", 8'h48);
      wr("R3", 8'h44, 32'h0000_00F0); rd("R3", 8'h44);
      wr("R3", 8'h44, 32'h0);

      // R4: synchronizer latency
      idle("R4", 32'h0000_0101);
      rd("R4", 8'h50); rd("R4", 8'h50); rd("R4", 8'h50);

      // R5: level-high pin 3, level-low pin 5
      wr("R5", 8'h34, 32'h0);
      wr("R5", 8'h38, 32'h0000_0008);
      wr("R5", 8'h30, 32'h0000_0028);
      pin_in = 32'h0000_0028;
      rd("R5", 8'h3C); rd("R5", 8'h3C); rd("R5", 8'h3C);
      pin_in = 32'h0000_0000;
      rd("R5", 8'h3C); rd("R5", 8'h3C); rd("R5", 8'h3C);
      wr("R7", 8'h40, 32'hFFFF_FFFF);   // R7: no effect on level bits
      rd("R7", 8'h3C);
      wr("R9", 8'h44, 32'h0000_0020);   // R9: masked -> irq drops
      rd("R9", 8'h3C);
      wr("R9", 8'h44, 32'h0); wr("R5", 8'h30, 32'h0);

      // R6: rising edge pin 7, falling edge pin 9
      pin_in = 32'h0000_0200; idle("R6", pin_in); idle("R6", pin_in); idle("R6", pin_in);
      wr("R6", 8'h34, 32'h0000_0280);
      wr("R6", 8'h38, 32'h0000_0080);
      wr("R6", 8'h30, 32'h0000_0280);
      idle("R6", 32'h0000_0080); idle("R6", 32'h0000_0080); idle("R6", 32'h0000_0080);
      rd("R6", 8'h3C);
      idle("R6", 32'h0000_0200); idle("R6", 32'h0000_0200); idle("R6", 32'h0000_0200);
      rd("R6", 8'h3C);
      // R8: masked latch kept
      wr("R8", 8'h44, 32'h0000_0080); rd("R8", 8'h3C);
      wr("R8", 8'h44, 32'h0);         rd("R8", 8'h3C);
      // R7: clear, then clear colliding with a fresh edge
      wr("R7", 8'h40, 32'h0000_0280); rd("R7", 8'h3C); rd("R7", 8'h40);
      pin_in = 32'h0000_0280; idle("R7", pin_in); idle("R7", pin_in);
      wr("R7", 8'h40, 32'h0000_0080);
      rd("R7", 8'h3C);
      // R6: disabled pin ignores edges
      wr("R6", 8'h30, 32'h0); wr("R7", 8'h40, 32'hFFFF_FFFF);
      idle("R6", 0); idle("R6", 0); idle("R6", 0);
      wr("R6", 8'h30, 32'h0000_0280); rd("R6", 8'h3C);

      // R10: unmapped, unaligned, read-only targets
      wr("R10", 8'h3C, 32'hFFFF_FFFF); wr("R10", 8'h50, 32'hFFFF_FFFF);
      wr("R10", 8'h80, 32'hFFFF_FFFF); wr("R10", 8'h01, 32'hFFFF_FFFF);
      rd("R10", 8'h80); rd("R10", 8'h5C); rd("R10", 8'h01); rd("R10", 8'h00);

      // random mix, all requirements
      pins = pin_in;
      for (int n = 0; n < 3000; n++) begin
         int k = $urandom_range(0, 11);
         int kind = $urandom_range(0, 3);
         pins = pins ^ ($urandom & $urandom & $urandom);
         step("R9", kind != 3, kind != 2, kind == 0, amap[k], $urandom, pins);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule